// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Compare

This block is the execution datapath of a small integer core. It takes two 32-bit operands and a 4-bit operation code and returns one 32-bit result: wrapping add and subtract, the three bitwise operations, three kinds of shift, and signed and unsigned set-less-than. A select input swaps the second operand for a sign-extended 12-bit immediate, so the register-immediate forms of every operation share the same hardware.

The unit is purely combinational. The result follows the inputs within the same cycle and holds no state, so it needs no clock or reset. The surrounding pipeline registers its inputs and outputs as it sees fit. There is no dedicated inversion operation: a caller inverts a word by XOR with an all-ones operand.

Top module: `int_alu`

## Requirements
- R1: Operation code 0 returns operand A plus operand B modulo 2^32, with no overflow indication.
- R2: Operation code 1 returns operand A minus operand B modulo 2^32.
- R3: Operation codes 2, 3 and 4 return the bitwise AND, OR and XOR of the operands. XOR with 0xFFFFFFFF yields the bitwise inverse of A.
- R4: Operation code 5 shifts A left by the shift amount and fills the vacated low bits with zeros.
- R5: Operation code 6 shifts A right by the shift amount and fills the vacated high bits with zeros.
- R6: Operation code 7 shifts A right by the shift amount and fills the vacated high bits with copies of the original bit 31 of A.
- R7: The shift amount is bits 4:0 of the second operand. Bits 31:5 of the second operand have no effect on any shift.
- R8: Operation code 8 returns 1 when A is less than B as two's-complement signed numbers, and 0 otherwise.
- R9: Operation code 9 returns 1 when A is less than B as unsigned numbers, and 0 otherwise.
- R10: When use_imm is 1, the second operand is imm[11:0] sign-extended to 32 bits in place of op_b. When use_imm is 0, op_b is used.
- R11: Operation codes 10 through 15 return zero.
- R12: The result reflects the current inputs in the same cycle, with no register between inputs and result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (register form) |
| imm | input | 12 | Immediate, sign-extended when selected |
| use_imm | input | 1 | 1 selects the immediate as second operand |
| op | input | 4 | Operation code |
| result | output | 32 | Operation result |

## Verification
Every result is due zero cycles after its stimulus, because no register lies between the inputs and the result. The bench applies each input set one time unit after a rising clock edge and reads the result at the following falling edge. The output has therefore settled, and no check depends on how processes are ordered at the rising edge. Expected values come from a behavioural model inside the bench that uses the language's own signed and unsigned operators.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int DATA_W = 32;
  localparam int IMM_W  = 12;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SLL  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SRA  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic [W-1:0] diff,
  output logic         lt_s,
  output logic         lt_u
);
  logic [W:0] wide_diff;

  always_comb begin
    sum       = a + b;
    wide_diff = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
    diff      = wide_diff[W-1:0];
    lt_u      = ~wide_diff[W];
    lt_s      = (a[W-1] ^ b[W-1]) ? a[W-1] : wide_diff[W-1];
  end

  always_comb begin
    assert_sub_inverse_R2: assert ((diff + b) == a);
    if (a == b) begin
      assert_eq_not_less_R8: assert (!lt_s && !lt_u);
    end
    if (a[W-1] && !b[W-1]) begin
      assert_neg_below_pos_R8: assert (lt_s);
      assert_high_not_below_R9: assert (!lt_u);
    end
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W = 32,
  localparam int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    a,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    sll_r,
  output logic [W-1:0]    srl_r,
  output logic [W-1:0]    sra_r
);
  logic [W-1:0] l_st [0:SH_W];
  logic [W-1:0] r_st [0:SH_W];
  logic [W-1:0] s_st [0:SH_W];

  assign l_st[0] = a;
  assign r_st[0] = a;
  assign s_st[0] = a;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    localparam int STEP = 1 << i;
    assign l_st[i+1] = amt[i] ? {l_st[i][W-1-STEP:0], {STEP{1'b0}}} : l_st[i];
    assign r_st[i+1] = amt[i] ? {{STEP{1'b0}}, r_st[i][W-1:STEP]} : r_st[i];
    assign s_st[i+1] = amt[i] ? {{STEP{a[W-1]}}, s_st[i][W-1:STEP]} : s_st[i];
  end

  assign sll_r = l_st[SH_W];
  assign srl_r = r_st[SH_W];
  assign sra_r = s_st[SH_W];

  always_comb begin
    if (amt != '0) begin
      assert_sll_zero_fill_R4: assert (sll_r[0] == 1'b0);
      assert_srl_zero_fill_R5: assert (srl_r[W-1] == 1'b0);
      assert_sra_sign_fill_R6: assert (sra_r[W-1] == a[W-1]);
    end else begin
      assert_no_shift_R7: assert (sll_r == srl_r && srl_r == sra_r);
    end
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_r,
  output logic [W-1:0] or_r,
  output logic [W-1:0] xor_r
);
  assign and_r = a & b;
  assign or_r  = a | b;
  assign xor_r = a ^ b;

  always_comb begin
    assert_logic_consistent_R3: assert ((and_r | xor_r) == or_r);
    assert_and_xor_disjoint_R3: assert ((and_r & xor_r) == '0);
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int IMM_B = IMM_W,
  localparam int SH_W = $clog2(W)
) (
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic [IMM_B-1:0] imm,
  input  logic             use_imm,
  input  logic [OP_W-1:0]  op,
  output logic [W-1:0]     result
);
  logic [W-1:0] opnd_b;
  logic [W-1:0] sum, diff, and_r, or_r, xor_r, sll_r, srl_r, sra_r;
  logic         lt_s, lt_u;

  assign opnd_b = use_imm ? {{(W-IMM_B){imm[IMM_B-1]}}, imm} : op_b;

  alu_addsub #(.W(W)) u_addsub (
    .a(op_a), .b(opnd_b), .sum(sum), .diff(diff), .lt_s(lt_s), .lt_u(lt_u)
  );

  alu_logic #(.W(W)) u_logic (
    .a(op_a), .b(opnd_b), .and_r(and_r), .or_r(or_r), .xor_r(xor_r)
  );

  alu_shift #(.W(W)) u_shift (
    .a(op_a), .amt(opnd_b[SH_W-1:0]), .sll_r(sll_r), .srl_r(srl_r), .sra_r(sra_r)
  );

  always_comb begin
    case (op)
      OP_ADD:  result = sum;
      OP_SUB:  result = diff;
      OP_AND:  result = and_r;
      OP_OR:   result = or_r;
      OP_XOR:  result = xor_r;
      OP_SLL:  result = sll_r;
      OP_SRL:  result = srl_r;
      OP_SRA:  result = sra_r;
      OP_SLT:  result = {{(W-1){1'b0}}, lt_s};
      OP_SLTU: result = {{(W-1){1'b0}}, lt_u};
      default: result = '0;
    endcase
  end

  always_comb begin
    if (op > OP_SLTU) begin
      assert_unused_op_zero_R11: assert (result == '0);
    end
    if (op == OP_SLT || op == OP_SLTU) begin
      assert_compare_single_bit_R8: assert (result[W-1:1] == '0);
    end
    if (use_imm) begin
      assert_imm_sign_ext_R10: assert (opnd_b[W-1] == imm[IMM_B-1]);
    end
  end
endmodule

// File: tb/int_alu_tb.sv
module int_alu_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [11:0] imm = '0;
  logic        use_imm = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] result;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu u_dut (
    .op_a(op_a), .op_b(op_b), .imm(imm), .use_imm(use_imm), .op(op), .result(result)
  );

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] a,
                                        input logic [31:0] b);
    case (o)
      4'd0: return a + b;
      4'd1: return a - b;
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return a ^ b;
      4'd5: return a << b[4:0];
      4'd6: return a >> b[4:0];
      4'd7: return $unsigned($signed(a) >>> b[4:0]);
      4'd8: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd9: return (a < b) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic ui, input logic [11:0] im);
    @(posedge clk);
    #1;
    op = o; op_a = a; op_b = b; use_imm = ui; imm = im;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] exp);
    n_checks++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s: op=%0d a=%h b=%h actual=%h expected=%h", req, op, op_a, op_b,
               result, exp);
    end
  endtask

  task automatic t_idle();
    apply(4'd0, 32'h0, 32'h0, 1'b0, 12'h0);
    chk("R12 idle", 32'h0);
    apply(4'd0, 32'd7, 32'd5, 1'b0, 12'h0);
    chk("R12 same cycle", 32'd12);
  endtask

  task automatic t_addsub();
    apply(4'd0, 32'hFFFF_FFFF, 32'h1, 1'b0, 12'h0);
    chk("R1 wrap", 32'h0);
    apply(4'd0, 32'h7FFF_FFFF, 32'h1, 1'b0, 12'h0);
    chk("R1 signed overflow", 32'h8000_0000);
    apply(4'd1, 32'h0, 32'h1, 1'b0, 12'h0);
    chk("R2 borrow", 32'hFFFF_FFFF);
    apply(4'd1, 32'd100, 32'd42, 1'b0, 12'h0);
    chk("R2 plain", 32'd58);
  endtask

  task automatic t_logic();
    apply(4'd4, 32'h1234_5678, 32'hFFFF_FFFF, 1'b0, 12'h0);
    chk("R3 invert", 32'hEDCB_A987);
    apply(4'd2, 32'hF0F0_F0F0, 32'h0000_00FF, 1'b0, 12'h0);
    chk("R3 and mask", 32'h0000_00F0);
    apply(4'd3, 32'hF000_0000, 32'h0000_000F, 1'b0, 12'h0);
    chk("R3 or", 32'hF000_000F);
  endtask

  task automatic t_shifts();
    apply(4'd5, 32'h8000_0001, 32'd4, 1'b0, 12'h0);
    chk("R4 sll", 32'h0000_0010);
    apply(4'd6, 32'hF000_0000, 32'd4, 1'b0, 12'h0);
    chk("R5 srl", 32'h0F00_0000);
    apply(4'd7, 32'hF000_0000, 32'd4, 1'b0, 12'h0);
    chk("R6 sra neg", 32'hFF00_0000);
    apply(4'd7, 32'h7000_0000, 32'd4, 1'b0, 12'h0);
    chk("R6 sra pos", 32'h0700_0000);
    apply(4'd7, 32'h8000_0000, 32'd31, 1'b0, 12'h0);
    chk("R6 sra max", 32'hFFFF_FFFF);
  endtask

  task automatic t_shamt();
    apply(4'd5, 32'h1, 32'hFFFF_FFE1, 1'b0, 12'h0);
    chk("R7 sll upper ignored", 32'h2);
    apply(4'd6, 32'h8000_0000, 32'h0000_0020, 1'b0, 12'h0);
    chk("R7 srl by 32 is 0", 32'h8000_0000);
    apply(4'd7, 32'h8000_0000, 32'h0000_0040, 1'b0, 12'h0);
    chk("R7 sra by 64 is 0", 32'h8000_0000);
  endtask

  task automatic t_compare();
    apply(4'd8, 32'hFFFF_FFFF, 32'h1, 1'b0, 12'h0);
    chk("R8 -1<1", 32'd1);
    apply(4'd8, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 12'h0);
    chk("R8 max<min", 32'd0);
    apply(4'd8, 32'd5, 32'd5, 1'b0, 12'h0);
    chk("R8 equal", 32'd0);
    apply(4'd9, 32'hFFFF_FFFF, 32'h1, 1'b0, 12'h0);
    chk("R9 big<1", 32'd0);
    apply(4'd9, 32'h1, 32'h8000_0000, 1'b0, 12'h0);
    chk("R9 1<big", 32'd1);
    apply(4'd9, 32'd9, 32'd9, 1'b0, 12'h0);
    chk("R9 equal", 32'd0);
  endtask

  task automatic t_imm();
    apply(4'd0, 32'd5, 32'd1000, 1'b1, 12'hFF6);
    chk("R10 add -10", 32'hFFFF_FFFB);
    apply(4'd9, 32'd5, 32'd0, 1'b1, 12'hFFF);
    chk("R10 sltu imm -1", 32'd1);
    apply(4'd0, 32'd5, 32'd0, 1'b1, 12'h7FF);
    chk("R10 positive imm", 32'd2052);
    apply(4'd4, 32'h0000_1234, 32'd0, 1'b1, 12'hFFF);
    chk("R10 xori invert", 32'hFFFF_EDCB);
  endtask

  task automatic t_unused();
    for (int o = 10; o < 16; o++) begin
      apply(4'(o), 32'hDEAD_BEEF, 32'h1234_5678, 1'b0, 12'h0);
      chk("R11 unused op", 32'h0);
    end
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      for (int o = 0; o < 10; o++) begin
        logic [31:0] a, b;
        a = $urandom();
        b = $urandom();
        apply(4'(o), a, b, 1'b0, 12'h0);
        chk("R1 R2 R3 R4 R5 R6 R8 R9 random", model(4'(o), a, b));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_idle();
    t_addsub();
    t_logic();
    t_shifts();
    t_shamt();
    t_compare();
    t_imm();
    t_unused();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule